// File: doc/BRIEF.md
# Trigger-Positioned Circular Capture Buffer

This block is the storage half of an on-chip logic analyser. While it is armed it writes one word of probe signals into on-chip memory on every rising clock edge. The write pointer runs in a ring, so the newest history before a trigger is always kept. When a trigger pulse arrives, the block records a fixed number of further samples. That number depends on a trigger position chosen when the block is armed. The block then stops writing and raises a completion flag. A host-side reader then walks a read index from zero upward and gets back the stored words in time order, oldest first.

The controller has four states. `S_IDLE` is the state after reset, with nothing recorded yet. `S_PRE` records history and waits for a trigger. `S_POST` records the samples after the trigger. `S_DONE` holds the result. An arm pulse moves the controller from any state to `S_PRE`. In `S_PRE`, a trigger moves it to `S_POST`, or straight to `S_DONE` when the post-trigger length is one. In `S_POST`, recording the last post-trigger sample moves it to `S_DONE`.

The post-trigger length is fixed at elaboration for each of three positions. If the trigger comes early, so that fewer than DEPTH samples were recorded since arming, the valid count tells the reader how many locations hold real data.

Top module: `trace_capture_buf`

## Requirements
- R1: Exactly one probe word is written on each rising edge while `capturing` is high. No write happens on the edge that registers an arm, or while the block is in `S_IDLE` or `S_DONE`.
- R2: The write address wraps from DEPTH-1 to 0. Before the trigger, older samples are overwritten, so the stored data is always the most recent DEPTH samples.
- R3: The post-trigger length is set by `pos_sel`. Code 0 gives round(DEPTH×0.88), 1 or 3 gives DEPTH/2, and 2 gives round(DEPTH×0.12); each length is at least 1. The sample written on the trigger edge counts as the first post-trigger sample. `done` goes high right after the edge that writes the last one.
- R4: `trig` has no effect in `S_IDLE` or `S_DONE`. While in `S_POST`, further trigger pulses do not change the capture length.
- R5: An arm pulse clears `done` and `valid_cnt` and sets `capturing` after its edge, in any state. `pos_sel` is sampled only on that edge; later changes are ignored.
- R6: `valid_cnt` equals the number of samples written since the last arm, saturating at DEPTH.
- R7: One cycle after `rd_idx` = i, `rd_data` holds the i-th oldest stored sample. Index 0 is the oldest sample, and the address wraps modulo DEPTH.
- R8: `capturing` is high exactly in `S_PRE` and `S_POST`, and `done` is high exactly in `S_DONE`. The two are never high together.
- R9: After reset, `done`, `capturing` and `valid_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | One-cycle pulse that restarts capture |
| trig | input | 1 | Trigger indication from an external evaluator |
| pos_sel | input | 2 | Trigger position: 0 early, 1/3 centre, 2 late |
| probe | input | WIDTH | Probe word sampled on each edge |
| rd_idx | input | AW | Readout index counted from the oldest sample |
| rd_data | output | WIDTH | Registered readout word |
| done | output | 1 | Capture complete |
| capturing | output | 1 | Capture in progress |
| valid_cnt | output | AW+1 | Number of locations holding captured data |

## Verification
The properties make few assumptions about the inputs. `arm` and `trig` may arrive in any state, and arm always takes priority, so the checks on valid-count growth leave out the arm cycle. The properties assume a single clock domain with inputs that are stable around the edge. The bench drives all inputs on the falling edge. Readout is only meaningful for indices below `valid_cnt`, so the stimulus reads only those locations and compares them against its own log of the probe words.

// File: rtl/trace_capture_pkg.sv
package trace_capture_pkg;

    typedef enum logic [1:0] {
        POS_EARLY   = 2'd0,
        POS_MID     = 2'd1,
        POS_LATE    = 2'd2,
        POS_MID_ALT = 2'd3
    } trig_pos_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_PRE  = 2'd1,
        S_POST = 2'd2,
        S_DONE = 2'd3
    } cap_state_e;

    // Rounded share of the depth in percent, clamped to [1, depth].
    function automatic int unsigned share_of(input int unsigned depth,
                                             input int unsigned pct);
        int unsigned r;
        r = (depth * pct + 50) / 100;
        if (r < 1) r = 1;
        if (r > depth) r = depth;
        return r;
    endfunction

endpackage

// File: rtl/trace_capture_fsm.sv
module trace_capture_fsm
    import trace_capture_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic trig,
    input  logic post_last,
    output logic clr,
    output logic wr_en,
    output logic post_step,
    output logic finish,
    output logic capturing,
    output logic done
);

    cap_state_e state, state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    // Next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE: if (arm) state_nxt = S_PRE;
            S_PRE: begin
                if (arm)       state_nxt = S_PRE;
                else if (trig) state_nxt = post_last ? S_DONE : S_POST;
            end
            S_POST: begin
                if (arm)            state_nxt = S_PRE;
                else if (post_last) state_nxt = S_DONE;
            end
            S_DONE: if (arm) state_nxt = S_PRE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        clr       = arm;
        wr_en     = 1'b0;
        post_step = 1'b0;
        capturing = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_PRE: begin
                capturing = 1'b1;
                wr_en     = !arm;
                post_step = !arm && trig;
            end
            S_POST: begin
                capturing = 1'b1;
                wr_en     = !arm;
                post_step = !arm;
            end
            S_DONE: done = 1'b1;
            default: ;
        endcase
        finish = post_step && post_last;
    end

endmodule

// File: rtl/trace_capture_ptr.sv
module trace_capture_ptr
    import trace_capture_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [1:0]    pos_sel,
    input  logic          wr_en,
    input  logic          post_step,
    input  logic          finish,
    output logic [AW-1:0] wr_addr,
    output logic          post_last,
    output logic [CW-1:0] fill_cnt,
    output logic [AW-1:0] base_addr
);

    localparam logic [CW-1:0] LEN_EARLY = CW'(share_of(DEPTH, 88));
    localparam logic [CW-1:0] LEN_MID   = CW'(share_of(DEPTH, 50));
    localparam logic [CW-1:0] LEN_LATE  = CW'(share_of(DEPTH, 12));
    localparam logic [CW-1:0] FULL      = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_A    = AW'(DEPTH - 1);
    localparam logic [AW-1:0] ONE_A     = AW'(1);
    localparam logic [CW-1:0] ONE_C     = CW'(1);

    logic [CW-1:0] post_len, post_cnt, post_nxt, fill_nxt;
    logic [AW-1:0] wr_addr_nxt;
    logic [CW-1:0] len_sel;

    always_comb begin
        unique case (trig_pos_e'(pos_sel))
            POS_EARLY:   len_sel = LEN_EARLY;
            POS_LATE:    len_sel = LEN_LATE;
            POS_MID,
            POS_MID_ALT: len_sel = LEN_MID;
            default:     len_sel = LEN_MID;
        endcase
    end

    assign post_nxt    = post_cnt + ONE_C;
    assign post_last   = (post_nxt == post_len);
    assign wr_addr_nxt = (wr_addr == LAST_A) ? '0 : wr_addr + ONE_A;
    assign fill_nxt    = (fill_cnt == FULL) ? fill_cnt : fill_cnt + ONE_C;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            post_len  <= LEN_MID;
            post_cnt  <= '0;
            fill_cnt  <= '0;
            wr_addr   <= '0;
            base_addr <= '0;
        end else if (clr) begin
            post_len  <= len_sel;
            post_cnt  <= '0;
            fill_cnt  <= '0;
            wr_addr   <= '0;
            base_addr <= '0;
        end else begin
            if (wr_en) begin
                wr_addr  <= wr_addr_nxt;
                fill_cnt <= fill_nxt;
            end
            if (post_step) post_cnt <= post_nxt;
            if (finish)    base_addr <= (fill_nxt == FULL) ? wr_addr_nxt : '0;
        end
    end

endmodule

// File: rtl/trace_capture_ram.sv
module trace_capture_ram #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end

endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             trig,
    input  logic [1:0]       pos_sel,
    input  logic [WIDTH-1:0] probe,
    input  logic [AW-1:0]    rd_idx,
    output logic [WIDTH-1:0] rd_data,
    output logic             done,
    output logic             capturing,
    output logic [CW-1:0]    valid_cnt
);

    logic          clr, wr_en, post_step, finish, post_last;
    logic [AW-1:0] wr_addr, base_addr, rd_addr;
    logic [CW-1:0] rd_sum, rd_wrapped;

    trace_capture_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .trig      (trig),
        .post_last (post_last),
        .clr       (clr),
        .wr_en     (wr_en),
        .post_step (post_step),
        .finish    (finish),
        .capturing (capturing),
        .done      (done)
    );

    trace_capture_ptr #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .pos_sel   (pos_sel),
        .wr_en     (wr_en),
        .post_step (post_step),
        .finish    (finish),
        .wr_addr   (wr_addr),
        .post_last (post_last),
        .fill_cnt  (valid_cnt),
        .base_addr (base_addr)
    );

    // Oldest-relative index to physical address, wrapping modulo DEPTH
    assign rd_sum     = {1'b0, base_addr} + {1'b0, rd_idx};
    assign rd_wrapped = (rd_sum >= CW'(DEPTH)) ? rd_sum - CW'(DEPTH) : rd_sum;
    assign rd_addr    = rd_wrapped[AW-1:0];

    trace_capture_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (probe),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/trace_capture_sva.sv
module trace_capture_sva #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          done,
    input logic          capturing,
    input logic [CW-1:0] valid_cnt
);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && capturing));

    p_valid_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_cnt <= CW'(DEPTH));

    p_valid_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (capturing && !arm && valid_cnt < CW'(DEPTH))
        |=> (valid_cnt == CW'($past(valid_cnt) + CW'(1))));

    p_idle_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!capturing && !arm) |=> (!capturing && $stable(done) && $stable(valid_cnt)));

    p_arm_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!done && capturing && valid_cnt == '0));

    p_done_after_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(capturing));

endmodule

bind trace_capture_buf trace_capture_sva #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .done      (done),
    .capturing (capturing),
    .valid_cnt (valid_cnt)
);

// File: tb/trace_capture_buf_test.sv
module trace_capture_buf_test;

    localparam int W  = 8;
    localparam int D  = 16;
    localparam int A  = 4;
    localparam int NV = 6;

    // {pos at arm[23:22], pos during run[21:20], pre cycles[19:10], post len[9:5], valid[4:0]}
    localparam logic [23:0] VEC [NV] = '{
        {2'd0, 2'd0, 10'd0,  5'd14, 5'd14},
        {2'd1, 2'd1, 10'd20, 5'd8,  5'd16},
        {2'd2, 2'd2, 10'd30, 5'd2,  5'd16},
        {2'd0, 2'd2, 10'd1,  5'd14, 5'd15},
        {2'd2, 2'd0, 10'd3,  5'd2,  5'd5},
        {2'd3, 2'd1, 10'd10, 5'd8,  5'd16}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arm = 1'b0;
    logic         trig = 1'b0;
    logic [1:0]   pos_sel = 2'd0;
    logic [W-1:0] probe = '0;
    logic [A-1:0] rd_idx = '0;
    logic [W-1:0] rd_data;
    logic         done, capturing;
    logic [A:0]   valid_cnt;

    logic [W-1:0] hist [64];
    logic [W-1:0] val = 8'h30;
    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    trace_capture_buf #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig(trig), .pos_sel(pos_sel),
        .probe(probe), .rd_idx(rd_idx), .rd_data(rd_data), .done(done),
        .capturing(capturing), .valid_cnt(valid_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_arm(input logic [1:0] pos);
        @(negedge clk);
        arm = 1'b1; pos_sel = pos; probe = 8'hEE;
        @(posedge clk); @(negedge clk);
        arm = 1'b0;
        chk(!done && capturing && valid_cnt == 0, "R5 arm clears", {done, capturing, 3'b0} | int'(valid_cnt), 8);
    endtask

    // Runs pre-trigger cycles then post-trigger cycles; logs every written word.
    task automatic run(input logic [1:0] pos_run, input int pre, input int post, input bit hold_trig);
        for (int k = 0; k < pre + post; k++) begin
            probe = val; hist[k] = val; val = val + 8'd7;
            trig = (k == pre) || (hold_trig && k > pre);
            pos_sel = pos_run;
            if (k == pre + post - 1)
                chk(!done, "R3 done not early", int'(done), 0);
            @(posedge clk); @(negedge clk);
        end
        trig = 1'b0;
        chk(done, "R3 done after last post sample", int'(done), 1);
        chk(!capturing, "R8 capture stopped", int'(capturing), 0);
    endtask

    task automatic readout(input int total, input int nvalid, input string tag);
        for (int i = 0; i < nvalid; i++) begin
            rd_idx = A'(i);
            @(posedge clk); @(negedge clk);
            chk(rd_data == hist[total - nvalid + i], tag, int'(rd_data), int'(hist[total - nvalid + i]));
        end
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset state
        #20;
        chk(!done && !capturing && valid_cnt == 0, "R9 reset state", int'(valid_cnt), 0);
        @(negedge clk); rst_n = 1'b1;

        // R4: triggers while idle are ignored
        for (int k = 0; k < 3; k++) begin
            trig = 1'b1; probe = val;
            @(posedge clk); @(negedge clk);
        end
        trig = 1'b0;
        chk(!done && !capturing && valid_cnt == 0, "R4 idle trigger ignored", int'(valid_cnt), 0);

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic [23:0] e;
            int pre, post, nv;
            e = VEC[v];
            pre = int'(e[19:10]); post = int'(e[9:5]); nv = int'(e[4:0]);
            do_arm(e[23:22]);
            run(e[21:20], pre, post, 1'b0);
            chk(valid_cnt == A'(0) + (A+1)'(nv), "R6 valid count", int'(valid_cnt), nv);
            // R4/R1: triggers and new probe values in done state change nothing
            for (int k = 0; k < 3; k++) begin
                trig = 1'b1; probe = ~val;
                @(posedge clk); @(negedge clk);
            end
            trig = 1'b0;
            chk(done && valid_cnt == (A+1)'(nv), "R4 done trigger ignored", int'(valid_cnt), nv);
            readout(pre + post, nv, "R7/R2/R1 readout oldest first");
        end

        // R5: re-arm in mid capture restarts; R4: trigger held high through post
        do_arm(2'd1);
        for (int k = 0; k < 5; k++) begin
            probe = val; val = val + 8'd3;
            @(posedge clk); @(negedge clk);
        end
        chk(valid_cnt == 5, "R6 partial fill", int'(valid_cnt), 5);
        do_arm(2'd1);
        run(2'd1, 2, 8, 1'b1);
        chk(valid_cnt == 10, "R5 re-arm valid count", int'(valid_cnt), 10);
        readout(10, 10, "R5 re-arm readout");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule